// File: doc/BRIEF.md
# AUX Channel Preamble Generator

This block produces the opening preamble of a transaction on a half-duplex auxiliary display channel that uses Manchester-II coding. After a start request it drives the serial line through three phases. First comes an optional extra precharge portion. Next comes a fixed run of 26 coded zeros. Last comes a sync-end marker. When the marker is complete, it gives a one-clock done strobe so that a downstream payload serializer can take over the line. Bit timing comes from a one-cycle sample enable that the system asserts twice per bit period (one microsecond), so each enable starts a new half-bit.

The extra portion is set by a small configuration register. Its reset value is 3. Each unit of the register adds two coded zeros. The channel rules allow at most 32 leading zeros, so any value above 3 raises an error flag. A mode bit selects how the extra portion is sent. In pulse mode it is sent as coded zeros. In DC mode the line is held at a steady level for the same duration, and only the fixed 26 zeros are coded. A counter of the coded zeros sent in the current preamble is exposed so that the count can be checked.

Top module: `aux_preamble_gen`

## Requirements
- R1: A coded zero takes two half-bits. The line is low for the first half-bit and high for the second, which gives a low-to-high transition in the middle of the bit.
- R2: In pulse mode (dc_mode=0), the preamble starts with 26 + 2*V consecutive coded zeros, where V is the configuration value captured at start. These zeros occupy half-bits 0 to 52+4V-1.
- R3: In DC mode (dc_mode=1), half-bits 0 to 4V-1 hold the line steadily high with no transitions. The next 52 half-bits carry exactly 26 coded zeros.
- R4: After the last coded zero, the line is high for 4 half-bits (two bit periods) and then low for 4 half-bits, with no mid-bit transitions.
- R5: line_out and line_oe change only on the clock edge at which half_tick is sampled high. Each half_tick starts the next half-bit.
- R6: line_oe rises together with the first half-bit and stays high through the last half-bit of the sync-end marker. Whenever line_oe is low, line_out is low. While idle, both are low.
- R7: done is high for exactly one clock. It rises on the half_tick edge that follows the final half-bit, and at that same edge line_oe and line_out fall.
- R8: The configuration register resets to 3, which gives 32 zeros in pulse mode. It is written when cfg_we=1. The value used by a preamble is the one the register holds when start is accepted, so a write during a preamble affects only later preambles.
- R9: cfg_err is high exactly when the register holds a value greater than 3, that is, when pulse mode would give more than 32 zeros.
- R10: start is accepted only while the block is idle. A start during a preamble has no effect on the line sequence or its length.
- R11: zero_count is cleared when start is accepted. It goes up by one with each coded zero completed, and it holds its final value after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle enable, two per bit period |
| start | input | 1 | Begin a preamble (honoured while idle) |
| dc_mode | input | 1 | 1: steady-level extra precharge, 0: coded-zero extra precharge |
| cfg_we | input | 1 | Write strobe for the extra-precharge register |
| cfg_wdata | input | EXTRA_W | Value written to the extra-precharge register |
| line_out | output | 1 | Serial channel line |
| line_oe | output | 1 | Line driver enable |
| done | output | 1 | One-clock strobe once the sync-end marker is finished |
| cfg_err | output | 1 | Register value would exceed the 32-zero limit |
| zero_count | output | ZC_W | Coded zeros sent in the current preamble |

## Verification
Two situations are hard to reach from the ports. One is a start that lands in the middle of a preamble. The other is a register write that lands after the value has been captured, because each one has to fall between particular half_tick pulses. The stimulus does both directly. It raises start and cfg_we during the idle gap after a chosen half-bit, and then it checks the whole line waveform and the final zero count against the value that was in force at start. Random register values, random mode bits and random gaps between ticks then cover the limit case (V=3) and the values beyond it.

// File: rtl/aux_pre_pkg.sv
package aux_pre_pkg;
  localparam int unsigned FIXED_ZEROS  = 26;
  localparam int unsigned MAX_ZEROS    = 32;
  localparam int unsigned END_HI_BITS  = 2;
  localparam int unsigned END_LO_BITS  = 2;
  localparam int unsigned RESET_EXTRA  = 3;
  localparam int unsigned EXTRA_LIMIT  = (MAX_ZEROS - FIXED_ZEROS) / 2;
  localparam int unsigned FIXED_HB     = 2 * (FIXED_ZEROS + END_HI_BITS + END_LO_BITS);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/aux_pre_cfg.sv
module aux_pre_cfg
  import aux_pre_pkg::*;
#(
  parameter int unsigned EXTRA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [EXTRA_W-1:0] wr_data,
  output logic [EXTRA_W-1:0] value,
  output logic               over_limit
);
  localparam logic [EXTRA_W-1:0] RST_V   = EXTRA_W'(RESET_EXTRA);
  localparam logic [EXTRA_W-1:0] LIMIT_V = EXTRA_W'(EXTRA_LIMIT);

  logic [EXTRA_W-1:0] value_q, value_d;

  always_comb begin
    value_d = value_q;
    if (wr_en) value_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= RST_V;
    else        value_q <= value_d;
  end

  assign value      = value_q;
  assign over_limit = (value_q > LIMIT_V);
endmodule

// File: rtl/aux_pre_enc.sv
module aux_pre_enc
  import aux_pre_pkg::*;
#(
  parameter int unsigned IDX_W    = 7,
  parameter logic        DC_LEVEL = 1'b1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] extra_hb,
  input  logic             dc_sel,
  output logic             level,
  output logic             zero_done
);
  localparam logic [IDX_W-1:0] ZERO_HB = IDX_W'(2 * FIXED_ZEROS);
  localparam logic [IDX_W-1:0] HI_HB   = IDX_W'(2 * END_HI_BITS);

  logic [IDX_W-1:0] zero_end, hi_end;

  assign zero_end = extra_hb + ZERO_HB;
  assign hi_end   = zero_end + HI_HB;

  always_comb begin
    level     = 1'b0;
    zero_done = 1'b0;
    if (idx < extra_hb) begin
      level     = dc_sel ? DC_LEVEL : idx[0];
      zero_done = !dc_sel && idx[0];
    end else if (idx < zero_end) begin
      level     = idx[0];
      zero_done = idx[0];
    end else if (idx < hi_end) begin
      level     = 1'b1;
    end else begin
      level     = 1'b0;
    end
  end
endmodule

// File: rtl/aux_pre_seq.sv
module aux_pre_seq
  import aux_pre_pkg::*;
#(
  parameter int unsigned EXTRA_W = 4,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned ZC_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_tick,
  input  logic               start,
  input  logic               dc_mode,
  input  logic [EXTRA_W-1:0] run_val,
  input  logic               level,
  input  logic               zero_done,
  output logic [IDX_W-1:0]   idx,
  output logic [IDX_W-1:0]   extra_hb,
  output logic               dc_sel,
  output logic               line,
  output logic               oe,
  output logic               done,
  output logic [ZC_W-1:0]    zcnt
);
  localparam logic [IDX_W-1:0] BASE_HB = IDX_W'(FIXED_HB);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] ehb_q, ehb_d;
  logic             dc_q, dc_d;
  logic             line_q, line_d;
  logic             oe_q, oe_d;
  logic             done_q, done_d;
  logic [ZC_W-1:0]  zcnt_q, zcnt_d;
  logic [IDX_W-1:0] total_hb;

  assign total_hb = ehb_q + BASE_HB;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ehb_d   = ehb_q;
    dc_d    = dc_q;
    line_d  = line_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    zcnt_d  = zcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          idx_d   = '0;
          ehb_d   = IDX_W'({run_val, 2'b00});
          dc_d    = dc_mode;
          zcnt_d  = '0;
        end
      end
      ST_RUN: begin
        if (half_tick) begin
          if (idx_q == total_hb) begin
            state_d = ST_IDLE;
            line_d  = 1'b0;
            oe_d    = 1'b0;
            done_d  = 1'b1;
          end else begin
            line_d = level;
            oe_d   = 1'b1;
            idx_d  = idx_q + IDX_W'(1);
            if (zero_done) zcnt_d = zcnt_q + ZC_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ehb_q   <= '0;
      dc_q    <= 1'b0;
      line_q  <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      zcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ehb_q   <= ehb_d;
      dc_q    <= dc_d;
      line_q  <= line_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
      zcnt_q  <= zcnt_d;
    end
  end

  assign idx      = idx_q;
  assign extra_hb = ehb_q;
  assign dc_sel   = dc_q;
  assign line     = line_q;
  assign oe       = oe_q;
  assign done     = done_q;
  assign zcnt     = zcnt_q;
endmodule

// File: rtl/aux_preamble_gen.sv
module aux_preamble_gen
  import aux_pre_pkg::*;
#(
  parameter int unsigned EXTRA_W  = 4,
  parameter int unsigned ZC_W     = 6,
  parameter logic        DC_LEVEL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_tick,
  input  logic               start,
  input  logic               dc_mode,
  input  logic               cfg_we,
  input  logic [EXTRA_W-1:0] cfg_wdata,
  output logic               line_out,
  output logic               line_oe,
  output logic               done,
  output logic               cfg_err,
  output logic [ZC_W-1:0]    zero_count
);
  localparam int unsigned MAX_HB = 4 * ((2 ** EXTRA_W) - 1) + FIXED_HB;
  localparam int unsigned IDX_W  = $clog2(MAX_HB + 1);

  logic [EXTRA_W-1:0] cfg_val;
  logic [IDX_W-1:0]   idx, extra_hb;
  logic               dc_sel, level, zero_done;

  aux_pre_cfg #(.EXTRA_W(EXTRA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_data    (cfg_wdata),
    .value      (cfg_val),
    .over_limit (cfg_err)
  );

  aux_pre_enc #(.IDX_W(IDX_W), .DC_LEVEL(DC_LEVEL)) u_enc (
    .idx       (idx),
    .extra_hb  (extra_hb),
    .dc_sel    (dc_sel),
    .level     (level),
    .zero_done (zero_done)
  );

  aux_pre_seq #(.EXTRA_W(EXTRA_W), .IDX_W(IDX_W), .ZC_W(ZC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .start     (start),
    .dc_mode   (dc_mode),
    .run_val   (cfg_val),
    .level     (level),
    .zero_done (zero_done),
    .idx       (idx),
    .extra_hb  (extra_hb),
    .dc_sel    (dc_sel),
    .line      (line_out),
    .oe        (line_oe),
    .done      (done),
    .zcnt      (zero_count)
  );
endmodule

// File: rtl/aux_pre_chk.sv
module aux_pre_chk #(
  parameter int unsigned ZC_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            half_tick,
  input logic            line_out,
  input logic            line_oe,
  input logic            done,
  input logic [ZC_W-1:0] zero_count
);
  p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(line_out));

  p_oe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(line_oe));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> !line_out);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!line_oe && $past(line_oe)));

  p_zcnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_count != $past(zero_count)) |->
      ((zero_count == $past(zero_count) + ZC_W'(1)) || (zero_count == '0)));
endmodule

bind aux_preamble_gen aux_pre_chk #(.ZC_W(ZC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_tick  (half_tick),
  .line_out   (line_out),
  .line_oe    (line_oe),
  .done       (done),
  .zero_count (zero_count)
);

// File: tb/tb_aux_preamble_gen.sv
`timescale 1ns/1ps
module tb_aux_preamble_gen;
  localparam int EW = 4;
  localparam int ZW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          half_tick, start, dc_mode, cfg_we;
  logic [EW-1:0] cfg_wdata;
  logic          line_out, line_oe, done, cfg_err;
  logic [ZW-1:0] zero_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int reg_model = 3;

  always #2 clk = ~clk;

  aux_preamble_gen #(.EXTRA_W(EW), .ZC_W(ZW), .DC_LEVEL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .start(start),
    .dc_mode(dc_mode), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .line_out(line_out), .line_oe(line_oe), .done(done),
    .cfg_err(cfg_err), .zero_count(zero_count)
  );

  function automatic int exp_level(int i, int v, bit dc);
    int e;
    e = 4 * v;
    if (i < e)      return dc ? 1 : (i % 2);
    if (i < e + 52) return i % 2;
    if (i < e + 56) return 1;
    return 0;
  endfunction

  function automatic string region_tag(int i, int v, bit dc);
    int e;
    e = 4 * v;
    if (i < e)      return dc ? "R3" : "R2";
    if (i < e + 52) return "R1";
    return "R4";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(int v);
    cfg_we = 1'b1;
    cfg_wdata = EW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    reg_model = v;
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  task automatic tick();
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
  endtask

  task automatic run_one(bit dc, bit mid_start, bit mid_write, int mid_val);
    int v, total, zeros;
    int prev;
    v = reg_model;
    total = 4 * v + 60;
    zeros = 0;
    prev = 1;
    chk(cfg_err == (v > 3), "R9 cfg_err", int'(cfg_err), int'(v > 3));
    dc_mode = dc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dc_mode = $urandom_range(0, 1);
    chk(line_oe == 1'b0, "R6 oe before first tick", int'(line_oe), 0);
    for (int i = 0; i < total; i++) begin
      gap();
      if (mid_start && i == 10) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (mid_write && i == 12) cfg_write(mid_val);
      tick();
      chk(int'(line_out) == exp_level(i, v, dc), region_tag(i, v, dc),
          int'(line_out), exp_level(i, v, dc));
      chk(line_oe == 1'b1, "R6 oe during preamble", int'(line_oe), 1);
      chk(done == 1'b0, "R7 done early", int'(done), 0);
      if ((i % 2 == 1) && (i < 4 * v + 52) && prev == 0 && line_out == 1'b1
          && !(dc && i < 4 * v)) zeros++;
      prev = int'(line_out);
    end
    chk(zeros == (dc ? 26 : 26 + 2 * v), dc ? "R3 zero total" : "R2 zero total",
        zeros, dc ? 26 : 26 + 2 * v);
    gap();
    tick();
    chk(done == 1'b1, "R7 done rises", int'(done), 1);
    chk(line_oe == 1'b0 && line_out == 1'b0, "R7 line released",
        int'({line_oe, line_out}), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one clock", int'(done), 0);
    chk(int'(zero_count) == (dc ? 26 : 26 + 2 * v), "R11 zero_count",
        int'(zero_count), dc ? 26 : 26 + 2 * v);
    for (int k = 0; k < 3; k++) begin
      gap();
      tick();
      chk(line_oe == 1'b0 && line_out == 1'b0, "R10 idle without start",
          int'({line_oe, line_out}), 0);
    end
    chk(int'(zero_count) == (dc ? 26 : 26 + 2 * v), "R11 zero_count holds",
        int'(zero_count), dc ? 26 : 26 + 2 * v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    half_tick = 1'b0;
    start = 1'b0;
    dc_mode = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_out == 1'b0 && line_oe == 1'b0 && done == 1'b0, "R6 reset outputs",
        int'({line_out, line_oe, done}), 0);
    chk(cfg_err == 1'b0, "R8 reset value within limit", int'(cfg_err), 0);
    chk(zero_count == '0, "R11 reset count", int'(zero_count), 0);

    // R8: default value 3 gives 32 zeros
    run_one(1'b0, 1'b0, 1'b0, 0);
    cfg_write(0); run_one(1'b0, 1'b0, 1'b0, 0);
    cfg_write(3); run_one(1'b1, 1'b0, 1'b0, 0);
    cfg_write(5); run_one(1'b0, 1'b0, 1'b0, 0);
    cfg_write(0); run_one(1'b1, 1'b0, 1'b0, 0);
    // R10: start mid-run ignored
    cfg_write(2); run_one(1'b0, 1'b1, 1'b0, 0);
    // R8: write mid-run only affects next run
    cfg_write(1);
    begin
      int nv;
      nv = 4;
      run_one(1'b0, 1'b0, 1'b1, nv);
    end
    chk(cfg_err == 1'b1, "R9 err after mid-run write", int'(cfg_err), 1);
    run_one(1'b1, 1'b0, 1'b0, 0);
    for (int r = 0; r < 8; r++) begin
      cfg_write($urandom_range(0, 15));
      run_one(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0, 0);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule